// File: doc/BRIEF.md
# Bit, Shift and Rotate Execution Unit (prefixed 8-bit group)

This unit executes one instruction from the prefixed bit-manipulation group of an 8-bit processor core. A caller presents the opcode byte and a mode flag that says whether the instruction is plain or indexed. It also presents the effective address (used in indexed mode), the HL pair, the packed register file, the high byte of the internal memory-pointer register and the current flags, and then pulses `start`. The unit reads its operand from a register or from memory. Memory access goes through a single-cycle port whose read data is combinational on the address. The unit then computes the result and issues, in one cycle marked by `done`, a register write, a memory write and a flag update, together with the T-state cost of the instruction.

The opcode splits into three fields. Bits 7:6 pick the operation group, bits 5:3 pick the shift kind or the bit index, and bits 2:0 pick the operand. In indexed mode the operand always comes from the effective address. When the instruction modifies its operand and bits 2:0 do not name memory, the result is also copied into the named register. The prefix fetch, the displacement fetch and the address arithmetic belong to the caller.

Top module: `bitop_unit`

## Requirements
- R1: Opcode bits 2:0 select the operand. Codes 0,1,2,3,4,5,7 are B,C,D,E,H,L,A, and register code k occupies byte k of `rf_in` (bits 8k+7:8k). Code 6 is the byte in memory at HL. A plain modifying instruction on a register writes the result with `reg_sel` equal to that code.
- R2: Opcode bits 7:6 = 0 selects a shift, and bits 5:3 select its kind. 0 is rotate left circular and 1 is rotate right circular. 2 is rotate left through carry and 3 is rotate right through carry. 4 is arithmetic left shift (a 0 enters bit 0) and 5 is arithmetic right shift (bit 7 kept). 6 is left shift with a 1 entering bit 0, and 7 is logical right shift.
- R3: The flag byte is laid out as S=7, Z=6, Y=5, H=4, X=3, P/V=2, N=1, C=0. After a shift, C holds the bit shifted out and S is result bit 7. Z is set for a zero result and P/V for even parity. Y and X are result bits 5 and 3, H and N are 0, and `flags_we` is 1.
- R4: Bits 7:6 = 1 tests bit y of the operand. Z and P/V are set when the bit is 0, H is 1 and N is 0. S is set only for y=7 with the bit at 1, and C is kept. For a register operand, Y and X come from operand bits 5 and 3. No register or memory write takes place.
- R5: A bit test on memory at HL takes Y and X from bits 5 and 3 of `memptr_hi`. An indexed bit test takes them from bits 5 and 3 of the effective address high byte.
- R6: Bits 7:6 = 2 clears bit y of the operand and bits 7:6 = 3 sets it. Both leave `flags_we` at 0.
- R7: A plain register instruction raises `done` for one cycle, one clock after the edge that accepts `start`. It reports 8 T-states and pulses `refresh_inc` with `done`.
- R8: A plain memory-at-HL instruction reads HL with `mem_rd`, and `done` comes two clocks after acceptance. A shift, clear or set writes the result back to HL and costs 15 T-states. A bit test does not write and costs 12.
- R9: An indexed instruction reads from `ea` and never pulses `refresh_inc`. A bit test costs 20 T-states and does not write. Every other operation costs 23 T-states and writes the result back to `ea`.
- R10: An indexed shift, clear or set with operand code other than 6 also writes the result to register `reg_sel` equal to that code. With code 6 no register is written.
- R11: A `start` pulse while `busy` is high is ignored. The running instruction completes unchanged and yields exactly one `done`.
- R12: After reset, `busy`, `done`, `mem_rd`, `mem_wr`, `reg_we`, `flags_we` and `refresh_inc` are all 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| start | input | 1 | Begin an instruction (accepted when idle) |
| indexed | input | 1 | 1 = indexed form, operand at `ea` |
| opcode | input | 8 | Instruction byte following the prefix |
| ea | input | ADDR_W | Effective address for indexed mode |
| hl | input | ADDR_W | HL register pair |
| rf_in | input | 64 | Packed register file, byte k = register code k |
| memptr_hi | input | 8 | High byte of the internal memory-pointer register |
| flags_in | input | 8 | Current flags |
| mem_rdata | input | 8 | Memory read data for `mem_addr` |
| busy | output | 1 | Instruction in progress |
| mem_rd | output | 1 | Memory read strobe |
| mem_addr | output | ADDR_W | Memory address for read and write |
| mem_wr | output | 1 | Memory write strobe |
| mem_wdata | output | 8 | Memory write data |
| done | output | 1 | One-cycle completion strobe |
| reg_we | output | 1 | Register write enable |
| reg_sel | output | 3 | Register code to write |
| reg_wdata | output | 8 | Register write data |
| flags_we | output | 1 | Flag update enable |
| flags_out | output | 8 | New flags |
| tstates | output | 5 | T-state cost of the finished instruction |
| refresh_inc | output | 1 | Refresh counter increment request |

## Verification
The assertions assume that `mem_rdata` is valid in the same cycle as `mem_addr`. They also assume that the caller holds `hl`, `ea`, `rf_in`, `memptr_hi` and `flags_in` stable from the `start` pulse until `done`. They check only how the strobes relate in time and which cost values are legal, and they rely on the fact that a completion never follows another directly. The bench models memory as a combinational array indexed by the low address byte. It changes inputs only on falling edges and keeps the operand inputs unchanged while an instruction runs. It breaks that rule only in the busy scenario, and only on `opcode` and `start`, which the unit must ignore there.

// File: rtl/bitop_pkg.sv
package bitop_pkg;

    localparam int BYTE_W   = 8;
    localparam int NREG     = 8;
    localparam int SEL_W    = 3;
    localparam int TS_W     = 5;

    localparam logic [SEL_W-1:0] OPND_MEM = 3'd6;

    localparam int TS_BASE     = 8;
    localparam int TS_BIT_MEM  = 4;
    localparam int TS_RMW_MEM  = 7;
    localparam int TS_IX_BIT   = 20;
    localparam int TS_IX_RMW   = 23;

    localparam int F_C  = 0;
    localparam int F_N  = 1;
    localparam int F_PV = 2;
    localparam int F_X  = 3;
    localparam int F_H  = 4;
    localparam int F_Y  = 5;
    localparam int F_Z  = 6;
    localparam int F_S  = 7;

    typedef enum logic [1:0] {
        GRP_SHIFT = 2'd0,
        GRP_TEST  = 2'd1,
        GRP_CLR   = 2'd2,
        GRP_SETB  = 2'd3
    } grp_e;

    typedef enum logic [2:0] {
        SH_RLC = 3'd0,
        SH_RRC = 3'd1,
        SH_RL  = 3'd2,
        SH_RR  = 3'd3,
        SH_SLA = 3'd4,
        SH_SRA = 3'd5,
        SH_SLL = 3'd6,
        SH_SRL = 3'd7
    } shk_e;

    typedef enum logic [1:0] {
        ST_IDLE,
        ST_FETCH,
        ST_EXEC
    } st_e;

    typedef struct packed {
        grp_e              grp;
        logic [SEL_W-1:0]  sel;
        logic [SEL_W-1:0]  opnd;
        logic              mem_src;
        logic              wr_mem;
        logic              wr_reg;
        logic [TS_W-1:0]   cost;
        logic              refresh;
    } ctrl_t;

    // Returns {carry_out, result}
    function automatic logic [BYTE_W:0] shift_calc(input shk_e k,
                                                   input logic [BYTE_W-1:0] v,
                                                   input logic cin);
        logic [BYTE_W-1:0] r;
        logic              co;
        unique case (k)
            SH_RLC: begin r = {v[6:0], v[7]};  co = v[7]; end
            SH_RRC: begin r = {v[0], v[7:1]};  co = v[0]; end
            SH_RL:  begin r = {v[6:0], cin};   co = v[7]; end
            SH_RR:  begin r = {cin, v[7:1]};   co = v[0]; end
            SH_SLA: begin r = {v[6:0], 1'b0};  co = v[7]; end
            SH_SRA: begin r = {v[7], v[7:1]};  co = v[0]; end
            SH_SLL: begin r = {v[6:0], 1'b1};  co = v[7]; end
            SH_SRL: begin r = {1'b0, v[7:1]};  co = v[0]; end
        endcase
        return {co, r};
    endfunction

    function automatic logic [BYTE_W-1:0] shift_flags(input logic [BYTE_W-1:0] r,
                                                      input logic co);
        logic [BYTE_W-1:0] f;
        f       = '0;
        f[F_S]  = r[7];
        f[F_Z]  = (r == '0);
        f[F_Y]  = r[5];
        f[F_X]  = r[3];
        f[F_PV] = ~^r;
        f[F_C]  = co;
        return f;
    endfunction

endpackage

// File: rtl/bitop_decode.sv
module bitop_decode
    import bitop_pkg::*;
(
    input  logic [BYTE_W-1:0] opcode,
    input  logic              indexed,
    output ctrl_t             ctrl
);
    logic modifies;
    logic at_hl;

    always_comb begin
        modifies      = (opcode[7:6] != 2'b01);
        at_hl         = (opcode[2:0] == OPND_MEM);
        ctrl.grp      = grp_e'(opcode[7:6]);
        ctrl.sel      = opcode[5:3];
        ctrl.opnd     = opcode[2:0];
        ctrl.mem_src  = indexed || at_hl;
        ctrl.wr_mem   = (indexed || at_hl) && modifies;
        ctrl.wr_reg   = modifies && !at_hl;
        ctrl.refresh  = !indexed;
        if (indexed)
            ctrl.cost = modifies ? TS_W'(TS_IX_RMW) : TS_W'(TS_IX_BIT);
        else if (at_hl)
            ctrl.cost = modifies ? TS_W'(TS_BASE + TS_RMW_MEM)
                                 : TS_W'(TS_BASE + TS_BIT_MEM);
        else
            ctrl.cost = TS_W'(TS_BASE);
    end
endmodule

// File: rtl/bitop_alu.sv
module bitop_alu
    import bitop_pkg::*;
(
    input  grp_e              grp,
    input  logic [SEL_W-1:0]  sel,
    input  logic              mem_src,
    input  logic [BYTE_W-1:0] opnd,
    input  logic [BYTE_W-1:0] flags_in,
    input  logic [BYTE_W-1:0] xy_src,
    output logic [BYTE_W-1:0] res,
    output logic [BYTE_W-1:0] flags,
    output logic              flags_we
);
    logic [BYTE_W:0]   sh;
    logic              tbit;
    logic [BYTE_W-1:0] xy;

    always_comb begin
        sh       = shift_calc(shk_e'(sel), opnd, flags_in[F_C]);
        tbit     = opnd[sel];
        xy       = mem_src ? xy_src : opnd;
        res      = opnd;
        flags    = flags_in;
        flags_we = 1'b0;
        unique case (grp)
            GRP_SHIFT: begin
                res      = sh[BYTE_W-1:0];
                flags    = shift_flags(sh[BYTE_W-1:0], sh[BYTE_W]);
                flags_we = 1'b1;
            end
            GRP_TEST: begin
                flags[F_S]  = (sel == 3'd7) && tbit;
                flags[F_Z]  = !tbit;
                flags[F_PV] = !tbit;
                flags[F_H]  = 1'b1;
                flags[F_N]  = 1'b0;
                flags[F_Y]  = xy[5];
                flags[F_X]  = xy[3];
                flags_we    = 1'b1;
            end
            GRP_CLR:  res[sel] = 1'b0;
            GRP_SETB: res[sel] = 1'b1;
        endcase
    end
endmodule

// File: rtl/bitop_unit.sv
module bitop_unit
    import bitop_pkg::*;
#(
    parameter int ADDR_W = 16
) (
    input  logic                    clk,
    input  logic                    rst,
    input  logic                    start,
    input  logic                    indexed,
    input  logic [BYTE_W-1:0]       opcode,
    input  logic [ADDR_W-1:0]       ea,
    input  logic [ADDR_W-1:0]       hl,
    input  logic [NREG*BYTE_W-1:0]  rf_in,
    input  logic [BYTE_W-1:0]       memptr_hi,
    input  logic [BYTE_W-1:0]       flags_in,
    input  logic [BYTE_W-1:0]       mem_rdata,
    output logic                    busy,
    output logic                    mem_rd,
    output logic [ADDR_W-1:0]       mem_addr,
    output logic                    mem_wr,
    output logic [BYTE_W-1:0]       mem_wdata,
    output logic                    done,
    output logic                    reg_we,
    output logic [SEL_W-1:0]        reg_sel,
    output logic [BYTE_W-1:0]       reg_wdata,
    output logic                    flags_we,
    output logic [BYTE_W-1:0]       flags_out,
    output logic [TS_W-1:0]         tstates,
    output logic                    refresh_inc
);
    localparam int HI_LSB = ADDR_W - BYTE_W;

    st_e               state;
    ctrl_t             ctrl_d, ctrl_q;
    logic [BYTE_W-1:0] opnd_q, flg_q, xy_q;
    logic [ADDR_W-1:0] addr_q;
    logic [BYTE_W-1:0] res_w, flg_w;
    logic              flg_we_w;
    logic [BYTE_W-1:0] rf_arr [NREG];

    for (genvar g = 0; g < NREG; g++) begin : g_rf
        assign rf_arr[g] = rf_in[g*BYTE_W +: BYTE_W];
    end

    bitop_decode u_dec (
        .opcode (opcode),
        .indexed(indexed),
        .ctrl   (ctrl_d)
    );

    bitop_alu u_alu (
        .grp     (ctrl_q.grp),
        .sel     (ctrl_q.sel),
        .mem_src (ctrl_q.mem_src),
        .opnd    (opnd_q),
        .flags_in(flg_q),
        .xy_src  (xy_q),
        .res     (res_w),
        .flags   (flg_w),
        .flags_we(flg_we_w)
    );

    assign busy     = (state != ST_IDLE);
    assign mem_rd   = (state == ST_FETCH);
    assign mem_addr = addr_q;

    always_ff @(posedge clk) begin
        if (rst) begin
            state       <= ST_IDLE;
            ctrl_q      <= '0;
            opnd_q      <= '0;
            flg_q       <= '0;
            xy_q        <= '0;
            addr_q      <= '0;
            done        <= 1'b0;
            reg_we      <= 1'b0;
            reg_sel     <= '0;
            reg_wdata   <= '0;
            mem_wr      <= 1'b0;
            mem_wdata   <= '0;
            flags_we    <= 1'b0;
            flags_out   <= '0;
            tstates     <= '0;
            refresh_inc <= 1'b0;
        end else begin
            done        <= 1'b0;
            reg_we      <= 1'b0;
            mem_wr      <= 1'b0;
            flags_we    <= 1'b0;
            refresh_inc <= 1'b0;
            case (state)
                ST_IDLE: begin
                    if (start) begin
                        ctrl_q <= ctrl_d;
                        addr_q <= indexed ? ea : hl;
                        flg_q  <= flags_in;
                        xy_q   <= indexed ? ea[HI_LSB +: BYTE_W] : memptr_hi;
                        opnd_q <= rf_arr[opcode[2:0]];
                        state  <= ctrl_d.mem_src ? ST_FETCH : ST_EXEC;
                    end
                end
                ST_FETCH: begin
                    opnd_q <= mem_rdata;
                    state  <= ST_EXEC;
                end
                ST_EXEC: begin
                    done        <= 1'b1;
                    reg_we      <= ctrl_q.wr_reg;
                    reg_sel     <= ctrl_q.opnd;
                    reg_wdata   <= res_w;
                    mem_wr      <= ctrl_q.wr_mem;
                    mem_wdata   <= res_w;
                    flags_we    <= flg_we_w;
                    flags_out   <= flg_w;
                    tstates     <= ctrl_q.cost;
                    refresh_inc <= ctrl_q.refresh;
                    state       <= ST_IDLE;
                end
                default: state <= ST_IDLE;
            endcase
        end
    end
endmodule

// File: rtl/bitop_unit_chk.sv
module bitop_unit_chk (
    input logic       clk,
    input logic       rst,
    input logic       busy,
    input logic       mem_rd,
    input logic       mem_wr,
    input logic       done,
    input logic       reg_we,
    input logic       flags_we,
    input logic [4:0] tstates,
    input logic       refresh_inc
);
    // R8: memory write only in the completion cycle
    p_memwr_at_done_r8: assert property (@(posedge clk) disable iff (rst)
        mem_wr |-> done);

    // R10: register write only in the completion cycle
    p_regwe_at_done_r10: assert property (@(posedge clk) disable iff (rst)
        reg_we |-> done);

    // R6: flag update only in the completion cycle
    p_fwe_at_done_r6: assert property (@(posedge clk) disable iff (rst)
        flags_we |-> done);

    // R7: completion is a single-cycle pulse
    p_done_pulse_r7: assert property (@(posedge clk) disable iff (rst)
        done |=> !done);

    // R7: only legal costs are reported
    p_cost_legal_r7: assert property (@(posedge clk) disable iff (rst)
        done |-> (tstates == 5'd8 || tstates == 5'd12 || tstates == 5'd15 ||
                  tstates == 5'd20 || tstates == 5'd23));

    // R7: plain register instruction touches no memory
    p_reg_nomem_r7: assert property (@(posedge clk) disable iff (rst)
        (done && tstates == 5'd8) |-> !mem_wr);

    // R9: refresh request only for plain forms
    p_refresh_plain_r9: assert property (@(posedge clk) disable iff (rst)
        refresh_inc |-> (done && tstates <= 5'd15));

    // R9: indexed bit test writes nothing
    p_ixbit_nowrite_r9: assert property (@(posedge clk) disable iff (rst)
        (done && tstates == 5'd20) |-> (!mem_wr && !reg_we));

    // R8: a read is followed by the execute cycle, never another read
    p_read_then_exec_r8: assert property (@(posedge clk) disable iff (rst)
        mem_rd |=> (busy && !mem_rd));

    // R8: read and write never overlap
    p_rd_wr_excl_r8: assert property (@(posedge clk) disable iff (rst)
        $onehot0({mem_rd, mem_wr}));

    // R11: the unit is idle again when it completes
    p_idle_at_done_r11: assert property (@(posedge clk) disable iff (rst)
        done |-> !busy);
endmodule

bind bitop_unit bitop_unit_chk u_chk (
    .clk        (clk),
    .rst        (rst),
    .busy       (busy),
    .mem_rd     (mem_rd),
    .mem_wr     (mem_wr),
    .done       (done),
    .reg_we     (reg_we),
    .flags_we   (flags_we),
    .tstates    (tstates),
    .refresh_inc(refresh_inc)
);

// File: tb/sim_bitop_unit.sv
`timescale 1ns/1ps
module sim_bitop_unit;
    localparam int AW = 16;

    logic          clk = 1'b0;
    logic          rst = 1'b1;
    logic          start = 1'b0;
    logic          indexed = 1'b0;
    logic [7:0]    opcode = '0;
    logic [AW-1:0] ea = '0;
    logic [AW-1:0] hl = '0;
    logic [63:0]   rf_in;
    logic [7:0]    memptr_hi = '0;
    logic [7:0]    flags_in = '0;
    logic [7:0]    mem_rdata;
    logic          busy, mem_rd, mem_wr, done, reg_we, flags_we, refresh_inc;
    logic [AW-1:0] mem_addr;
    logic [7:0]    mem_wdata, reg_wdata, flags_out;
    logic [2:0]    reg_sel;
    logic [4:0]    tstates;

    logic [7:0] rf  [8];
    logic [7:0] mem [256];

    int n_chk  = 0;
    int n_fail = 0;

    // expected values
    logic [7:0]  e_res, e_flg;
    logic        e_fwe, e_rwe, e_mwr, e_ref;
    logic [4:0]  e_ts;
    int          e_lat;
    logic [15:0] e_addr;

    always #2 clk = ~clk;

    assign rf_in = {rf[7], rf[6], rf[5], rf[4], rf[3], rf[2], rf[1], rf[0]};
    assign mem_rdata = mem[mem_addr[7:0]];

    always @(posedge clk) if (mem_wr) mem[mem_addr[7:0]] <= mem_wdata;

    bitop_unit #(.ADDR_W(AW)) u0 (
        .clk(clk), .rst(rst), .start(start), .indexed(indexed), .opcode(opcode),
        .ea(ea), .hl(hl), .rf_in(rf_in), .memptr_hi(memptr_hi), .flags_in(flags_in),
        .mem_rdata(mem_rdata), .busy(busy), .mem_rd(mem_rd), .mem_addr(mem_addr),
        .mem_wr(mem_wr), .mem_wdata(mem_wdata), .done(done), .reg_we(reg_we),
        .reg_sel(reg_sel), .reg_wdata(reg_wdata), .flags_we(flags_we),
        .flags_out(flags_out), .tstates(tstates), .refresh_inc(refresh_inc)
    );

    task automatic chk(input string req, input string what,
                       input logic [31:0] act, input logic [31:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s %s: actual %0h expected %0h", req, what, act, exp);
        end
    endtask

    function automatic logic [7:0] op_of(input logic [1:0] x, input logic [2:0] y,
                                         input logic [2:0] z);
        return {x, y, z};
    endfunction

    // Expected behaviour from the requirements
    task automatic model(input logic ix, input logic [7:0] op, input logic [15:0] adr);
        logic [1:0] x;
        logic [2:0] y, z;
        logic [7:0] v, r, xy;
        logic       c, b, memop;
        x = op[7:6]; y = op[5:3]; z = op[2:0];
        memop  = ix || (z == 3'd6);
        e_addr = ix ? adr : hl;
        v      = memop ? mem[e_addr[7:0]] : rf[z];
        r = v; c = flags_in[0]; e_flg = flags_in; e_fwe = 1'b0;
        case (x)
            2'd0: begin
                case (y)
                    3'd0: begin c = v[7]; r = {v[6:0], v[7]}; end
                    3'd1: begin c = v[0]; r = {v[0], v[7:1]}; end
                    3'd2: begin c = v[7]; r = {v[6:0], flags_in[0]}; end
                    3'd3: begin c = v[0]; r = {flags_in[0], v[7:1]}; end
                    3'd4: begin c = v[7]; r = {v[6:0], 1'b0}; end
                    3'd5: begin c = v[0]; r = {v[7], v[7:1]}; end
                    3'd6: begin c = v[7]; r = {v[6:0], 1'b1}; end
                    default: begin c = v[0]; r = {1'b0, v[7:1]}; end
                endcase
                e_flg = {r[7], r == 8'h00, r[5], 1'b0, r[3], ~^r, 1'b0, c};
                e_fwe = 1'b1;
            end
            2'd1: begin
                b  = v[y];
                xy = !memop ? v : (ix ? adr[15:8] : memptr_hi);
                e_flg = {(y == 3'd7) && b, !b, xy[5], 1'b1, xy[3], !b, 1'b0, flags_in[0]};
                e_fwe = 1'b1;
            end
            2'd2: r[y] = 1'b0;
            default: r[y] = 1'b1;
        endcase
        e_res = r;
        e_rwe = (x != 2'd1) && (z != 3'd6);
        e_mwr = (x != 2'd1) && memop;
        e_ref = !ix;
        e_lat = memop ? 3 : 2;
        if (ix)            e_ts = (x == 2'd1) ? 5'd20 : 5'd23;
        else if (z == 3'd6) e_ts = (x == 2'd1) ? 5'd12 : 5'd15;
        else               e_ts = 5'd8;
    endtask

    task automatic run_op(input string req, input logic ix, input logic [7:0] op,
                          input logic [15:0] adr);
        int lat;
        model(ix, op, adr);
        @(negedge clk);
        opcode = op; indexed = ix; ea = adr; start = 1'b1;
        @(negedge clk);
        start = 1'b0;
        lat = 1;
        while (!done && lat < 8) begin
            @(negedge clk);
            lat++;
        end
        chk(req, "latency", lat, e_lat);
        chk(req, "tstates", tstates, e_ts);
        chk(req, "flags_we", flags_we, e_fwe);
        if (e_fwe) chk(req, "flags", flags_out, e_flg);
        chk(req, "reg_we", reg_we, e_rwe);
        if (e_rwe) begin
            chk(req, "reg_sel", reg_sel, op[2:0]);
            chk(req, "reg_wdata", reg_wdata, e_res);
        end
        chk(req, "mem_wr", mem_wr, e_mwr);
        if (e_mwr) chk(req, "mem_addr", mem_addr, e_addr);
        chk(req, "refresh_inc", refresh_inc, e_ref);
        @(negedge clk);
        chk(req, "done_pulse", done, 0);
        if (e_mwr) chk(req, "mem_result", mem[e_addr[7:0]], e_res);
    endtask

    task automatic t_reset;
        rst = 1'b1;
        repeat (3) @(negedge clk);
        rst = 1'b0;
        @(negedge clk);
        chk("R12", "idle strobes",
            {busy, done, mem_rd, mem_wr, reg_we, flags_we, refresh_inc}, 0);
    endtask

    task automatic t_shift_kinds;
        rf[0] = 8'hA5; flags_in = 8'h01;
        for (int y = 0; y < 8; y++) run_op("R2", 1'b0, op_of(2'd0, 3'(y), 3'd0), 16'h0);
        rf[7] = 8'h80; flags_in = 8'h00;
        for (int y = 0; y < 8; y++) run_op("R3", 1'b0, op_of(2'd0, 3'(y), 3'd7), 16'h0);
    endtask

    task automatic t_operand_select;
        for (int k = 0; k < 8; k++) rf[k] = 8'(8'h13 * (k + 1));
        flags_in = 8'h00;
        for (int k = 0; k < 8; k++)
            if (k != 6) run_op("R1", 1'b0, op_of(2'd0, 3'd1, 3'(k)), 16'h0);
    endtask

    task automatic t_bit_reg;
        rf[2] = 8'h80; rf[3] = 8'h28; flags_in = 8'h01;
        run_op("R4", 1'b0, op_of(2'd1, 3'd7, 3'd2), 16'h0);
        run_op("R4", 1'b0, op_of(2'd1, 3'd0, 3'd2), 16'h0);
        run_op("R4", 1'b0, op_of(2'd1, 3'd3, 3'd3), 16'h0);
        flags_in = 8'h00;
        run_op("R4", 1'b0, op_of(2'd1, 3'd6, 3'd3), 16'h0);
    endtask

    task automatic t_bit_xy;
        hl = 16'h0040; mem[8'h40] = 8'h01; memptr_hi = 8'h28; flags_in = 8'h01;
        run_op("R5", 1'b0, op_of(2'd1, 3'd0, 3'd6), 16'h0);
        memptr_hi = 8'h00;
        run_op("R5", 1'b0, op_of(2'd1, 3'd1, 3'd6), 16'h0);
        mem[8'h50] = 8'h00;
        run_op("R5", 1'b1, op_of(2'd1, 3'd4, 3'd6), 16'h2050);
        run_op("R5", 1'b1, op_of(2'd1, 3'd4, 3'd1), 16'h0850);
    endtask

    task automatic t_res_set;
        rf[7] = 8'hFF; rf[1] = 8'h00; flags_in = 8'hC3;
        run_op("R6", 1'b0, op_of(2'd2, 3'd7, 3'd7), 16'h0);
        run_op("R6", 1'b0, op_of(2'd3, 3'd3, 3'd1), 16'h0);
    endtask

    task automatic t_mem_hl;
        hl = 16'h0070; mem[8'h70] = 8'h81; flags_in = 8'h00;
        run_op("R8", 1'b0, op_of(2'd0, 3'd2, 3'd6), 16'h0);
        run_op("R8", 1'b0, op_of(2'd3, 3'd5, 3'd6), 16'h0);
        run_op("R8", 1'b0, op_of(2'd0, 3'd7, 3'd6), 16'h0);
        run_op("R8", 1'b0, op_of(2'd2, 3'd1, 3'd6), 16'h0);
    endtask

    task automatic t_indexed;
        mem[8'h60] = 8'h3C; mem[8'h61] = 8'h41; mem[8'h62] = 8'h0F; mem[8'h63] = 8'h00;
        flags_in = 8'h01;
        run_op("R9", 1'b1, op_of(2'd0, 3'd1, 3'd6), 16'h1060);
        run_op("R10", 1'b1, op_of(2'd0, 3'd6, 3'd0), 16'h1061);
        run_op("R10", 1'b1, op_of(2'd2, 3'd2, 3'd3), 16'h1062);
        run_op("R10", 1'b1, op_of(2'd3, 3'd7, 3'd7), 16'h1063);
    endtask

    task automatic t_busy;
        int ndone;
        hl = 16'h0090; mem[8'h90] = 8'h00; rf[0] = 8'h55;
        model(1'b0, 8'hEE, 16'h0);
        @(negedge clk);
        opcode = 8'hEE; indexed = 1'b0; start = 1'b1;
        @(negedge clk);
        chk("R11", "busy", busy, 1);
        opcode = 8'h80;
        @(negedge clk);
        start = 1'b0;
        ndone = 0;
        for (int i = 0; i < 6; i++) begin
            if (done) begin
                ndone++;
                chk("R11", "tstates", tstates, 5'd15);
                chk("R11", "reg_we", reg_we, 0);
                chk("R11", "mem_wr", mem_wr, 1);
            end
            @(negedge clk);
        end
        chk("R11", "done count", ndone, 1);
        chk("R11", "mem_result", mem[8'h90], 8'h20);
    endtask

    initial begin
        for (int i = 0; i < 256; i++) mem[i] = 8'h00;
        for (int k = 0; k < 8; k++) rf[k] = 8'h00;
        t_reset;
        t_shift_kinds;
        t_operand_select;
        t_bit_reg;
        t_bit_xy;
        t_res_set;
        t_mem_hl;
        t_indexed;
        t_busy;
        $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
        $finish;
    end

    initial begin
        #400000;
        n_chk++;
        n_fail++;
        $display("FAIL watchdog: actual timeout expected completion");
        $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
        $finish;
    end
endmodule